// File: doc/BRIEF.md
# Stuck Bus Detect and Recovery

This block guards one side of a two-wire serial bus (SDA data, SCL clock). A watchdog counts every cycle in which either line is sampled low. It restarts only when both lines are sampled high together. If the count reaches its limit, the bus is declared stuck. The block then raises a sticky stuck flag and a driver-disable output for the normal signal path. It also sends a single-cycle request so that a disconnect message goes to the far side of the link.

After a programmable quiet gap, the block tries to free the bus. It toggles SCL through open-drain style pull-low controls, issuing at most sixteen clock pulses. It stops early as soon as it sees SDA high near the end of a high phase. It always finishes with a STOP condition: SDA is pulled low while SCL is low, SCL is released, and SDA is released half a period later. The stuck flag stays set until the connection controller clears it after the sequence is over. Dropping the enable input (undervoltage, overtemperature or low-power shutdown) holds the whole block idle.

Top module: `stuck_bus_guard`

## Requirements
- R1: While enabled and not stuck, the low-time count grows on every cycle in which SDA or SCL is sampled low. A cycle with both lines sampled high restarts it from zero.
- R2: `stuck` goes to 1 at the clock edge that completes `STUCK_CYCLES` consecutive samples in which at least one line is low. Fewer consecutive low samples never set it.
- R3: `drv_off` equals `stuck` in every cycle. `sda_pull` and `scl_pull` are both 0 whenever `stuck` is 0.
- R4: `disc_req` is 1 for exactly one cycle, the cycle in which `stuck` first reads 1.
- R5: The first `scl_pull`=1 appears exactly `GAP_CYCLES` cycles after `stuck` first reads 1. Until then, both pulls stay 0.
- R6: Each recovery clock pulse is `HALF_CYCLES` cycles with `scl_pull`=1 followed by `HALF_CYCLES` cycles with `scl_pull`=0. With SDA held low throughout, exactly `MAX_PULSES` (default 16) pulses are issued.
- R7: If SDA is sampled high on the last cycle of a high phase, no further pulses follow. The pulse count then equals the number of high phases issued.
- R8: After the last pulse, `sda_pull` and `scl_pull` rise in the same cycle. `scl_pull` falls after `HALF_CYCLES` cycles while `sda_pull` is still 1. `sda_pull` falls `HALF_CYCLES` cycles after that, with `scl_pull` at 0.
- R9: `stuck` stays 1 until `clr_stuck` is sampled 1 after the STOP has finished. A `clr_stuck` during the gap or the pulses is ignored.
- R10: While `en` is 0, the block neither detects nor recovers. The cycle after `en` is sampled 0, `stuck`, `drv_off`, `sda_pull` and `scl_pull` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block active; 0 in any shutdown condition |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| clr_stuck | input | 1 | Clear request from the connection controller |
| sda_pull | output | 1 | 1 pulls SDA low |
| scl_pull | output | 1 | 1 pulls SCL low |
| stuck | output | 1 | Sticky stuck-bus flag |
| drv_off | output | 1 | Disable for the normal SDA/SCL drivers |
| disc_req | output | 1 | One-cycle request to send the disconnect message |

## Verification
The watchdog is driven by a table of low patterns: SDA alone low, SCL alone low, both low, and both high. Each pattern is held for either one cycle short of the limit or exactly the limit. These cases separate a missed trip from an early one, and confirm that either line alone is enough to trip. Another case interrupts a low stretch with a single both-high cycle, which shows that the restart needs both lines. Recovery is tried in three ways. With SDA held low the whole time, the bench checks the full pulse bound, the gap and the STOP order. With the far device releasing SDA after its third clock, it checks early termination. With enable dropped mid-sequence, it checks that all pull-downs release at once. Clear requests are applied both during and after the sequence to test that the flag is sticky.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_WAIT,
        RS_LOW,
        RS_HIGH,
        RS_SDALO,
        RS_SCLREL,
        RS_DONE
    } rec_state_t;

    typedef struct packed {
        logic sda;
        logic scl;
    } pulls_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/stk_watchdog.sv
module stk_watchdog #(
    parameter int LIMIT = 4625000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic sda,
    input  logic scl,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          bus_low;

    assign bus_low = !(sda && scl);
    assign trip    = arm && bus_low && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !arm || !bus_low)
            cnt <= '0;
        else if (cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    // R1: a both-high sample restarts the count
    p_cnt_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (arm && sda && scl) |=> (cnt == '0));

    // R1: a low sample while armed advances the count
    p_cnt_grow_r1: assert property (@(posedge clk) disable iff (rst)
        (arm && bus_low && cnt < CW'(LIMIT - 1)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/stk_recovery.sv
module stk_recovery
    import stk_pkg::*;
#(
    parameter int GAP_CYCLES  = 5000,
    parameter int HALF_CYCLES = 625,
    parameter int MAX_PULSES  = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   start,
    input  logic   rearm,
    input  logic   sda_in,
    output pulls_t pulls,
    output logic   done
);
    localparam int TMAX = max_of(GAP_CYCLES, HALF_CYCLES);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(MAX_PULSES + 1);

    rec_state_t    state;
    logic [TW-1:0] tcnt;
    logic [PW-1:0] pcnt;
    logic          half_end;
    logic          gap_end;

    assign half_end = (tcnt == TW'(HALF_CYCLES - 1));
    assign gap_end  = (tcnt == TW'(GAP_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= RS_IDLE;
            tcnt  <= '0;
            pcnt  <= '0;
        end else begin
            case (state)
                RS_IDLE: begin
                    tcnt <= '0;
                    pcnt <= '0;
                    if (start) state <= RS_WAIT;
                end
                RS_WAIT: begin
                    if (gap_end) begin
                        state <= RS_LOW;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RS_LOW: begin
                    if (half_end) begin
                        state <= RS_HIGH;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RS_HIGH: begin
                    if (half_end) begin
                        tcnt <= '0;
                        if (sda_in || pcnt == PW'(MAX_PULSES - 1)) begin
                            state <= RS_SDALO;
                        end else begin
                            state <= RS_LOW;
                            pcnt  <= pcnt + 1'b1;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RS_SDALO: begin
                    if (half_end) begin
                        state <= RS_SCLREL;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RS_SCLREL: begin
                    if (half_end) begin
                        state <= RS_DONE;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RS_DONE: begin
                    if (rearm) state <= RS_IDLE;
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        pulls.scl = (state == RS_LOW) || (state == RS_SDALO);
        pulls.sda = (state == RS_SDALO) || (state == RS_SCLREL);
    end

    assign done = (state == RS_DONE);

    // R6: the pulse counter never passes the last allowed pulse
    p_pulse_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (pcnt <= PW'(MAX_PULSES - 1)));

    // R8: SDA is only pulled low while SCL is already pulled or being released
    p_sda_only_in_stop_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pulls.sda) |-> pulls.scl);
endmodule

// File: rtl/stuck_bus_guard.sv
module stuck_bus_guard
    import stk_pkg::*;
#(
    parameter int STUCK_CYCLES = 4625000,
    parameter int GAP_CYCLES   = 5000,
    parameter int HALF_CYCLES  = 625,
    parameter int MAX_PULSES   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sda_in,
    input  logic scl_in,
    input  logic clr_stuck,
    output logic sda_pull,
    output logic scl_pull,
    output logic stuck,
    output logic drv_off,
    output logic disc_req
);
    logic   trip;
    logic   seq_done;
    logic   stuck_q;
    logic   disc_q;
    pulls_t pulls;

    stk_watchdog #(.LIMIT(STUCK_CYCLES)) u_wdog (
        .clk  (clk),
        .rst  (rst),
        .arm  (en && !stuck_q),
        .sda  (sda_in),
        .scl  (scl_in),
        .trip (trip)
    );

    stk_recovery #(
        .GAP_CYCLES (GAP_CYCLES),
        .HALF_CYCLES(HALF_CYCLES),
        .MAX_PULSES (MAX_PULSES)
    ) u_rec (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .start (trip),
        .rearm (clr_stuck),
        .sda_in(sda_in),
        .pulls (pulls),
        .done  (seq_done)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            stuck_q <= 1'b0;
            disc_q  <= 1'b0;
        end else begin
            disc_q <= trip;
            if (trip)
                stuck_q <= 1'b1;
            else if (clr_stuck && seq_done)
                stuck_q <= 1'b0;
        end
    end

    assign stuck    = stuck_q;
    assign drv_off  = stuck_q;
    assign disc_req = disc_q;
    assign sda_pull = pulls.sda;
    assign scl_pull = pulls.scl;

    // R2: the flag only rises after a sample with a low line
    p_stuck_needs_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(stuck_q) |-> $past(!(sda_in && scl_in)));

    // R3: no pull-down is active outside a stuck episode
    p_no_pull_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !stuck_q |-> (!pulls.sda && !pulls.scl));

    // R4: the disconnect request is a single-cycle pulse
    p_disc_single_r4: assert property (@(posedge clk) disable iff (rst)
        disc_q |=> !disc_q);

    // R8: SDA release forms the STOP with SCL already released
    p_stop_order_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(pulls.sda) |-> !pulls.scl);

    // R9: the flag only falls on a clear or on disable
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(stuck_q) |-> $past(clr_stuck || !en));

    // R10: disable silences the block on the next cycle
    p_en_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!stuck_q && !pulls.sda && !pulls.scl));
endmodule

// File: tb/stuck_bus_guard_test.sv
module stuck_bus_guard_test;
    localparam int LIM  = 20;
    localparam int GAP  = 5;
    localparam int HALF = 3;
    localparam int MAXP = 16;
    localparam int NV   = 7;

    // vector: [9] sda level, [8] scl level, [7:1] cycles held, [0] expected stuck
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 1'b1, 7'd19, 1'b0},
        {1'b0, 1'b1, 7'd20, 1'b1},
        {1'b1, 1'b0, 7'd19, 1'b0},
        {1'b1, 1'b0, 7'd20, 1'b1},
        {1'b0, 1'b0, 7'd20, 1'b1},
        {1'b0, 1'b0, 7'd19, 1'b0},
        {1'b1, 1'b1, 7'd60, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic sda_drv = 1'b1;
    logic scl_drv = 1'b1;
    logic clr_stuck = 1'b0;
    logic sda_pull, scl_pull, stuck, drv_off, disc_req;
    logic sda_in, scl_in;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    int rises, falls, disc_cnt, rel_after;
    int t_stuck, t_first, t_scl_fall, t_sda_fall;
    bit sda_rise_scl, sda_fall_scl, drv_mismatch;
    logic p_scl, p_sda, p_stuck;

    always #4 clk = ~clk;

    assign sda_in = (sda_drv | (rel_after != 0 && falls >= rel_after)) & ~sda_pull;
    assign scl_in = scl_drv & ~scl_pull;

    stuck_bus_guard #(
        .STUCK_CYCLES(LIM), .GAP_CYCLES(GAP), .HALF_CYCLES(HALF), .MAX_PULSES(MAXP)
    ) uut (
        .clk(clk), .rst(rst), .en(en), .sda_in(sda_in), .scl_in(scl_in),
        .clr_stuck(clr_stuck), .sda_pull(sda_pull), .scl_pull(scl_pull),
        .stuck(stuck), .drv_off(drv_off), .disc_req(disc_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (scl_pull && !p_scl) begin
            rises++;
            if (t_first < 0) t_first = cyc;
        end
        if (!scl_pull && p_scl) begin
            falls++;
            t_scl_fall = cyc;
        end
        if (sda_pull && !p_sda) sda_rise_scl = scl_pull;
        if (!sda_pull && p_sda) begin
            t_sda_fall = cyc;
            sda_fall_scl = scl_pull;
        end
        if (stuck && !p_stuck) t_stuck = cyc;
        if (disc_req) disc_cnt++;
        if (drv_off !== stuck) drv_mismatch = 1;
        p_scl = scl_pull;
        p_sda = sda_pull;
        p_stuck = stuck;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        rises = 0; falls = 0; disc_cnt = 0;
        t_stuck = -1; t_first = -1; t_scl_fall = -1; t_sda_fall = -1;
        sda_rise_scl = 0; sda_fall_scl = 1; drv_mismatch = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; sda_drv = 1'b1; scl_drv = 1'b1; clr_stuck = 1'b0;
        rel_after = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clr_mon();
    endtask

    initial begin
        p_scl = 0; p_sda = 0; p_stuck = 0; rel_after = 0;
        clr_mon();
        do_reset();

        // reset state
        chk(!stuck && !drv_off && !sda_pull && !scl_pull && !disc_req, "R3 reset", stuck, 0);

        // table of low patterns (R2)
        for (int i = 0; i < NV; i++) begin
            do_reset();
            sda_drv = VEC[i][9];
            scl_drv = VEC[i][8];
            repeat (int'(VEC[i][7:1])) @(negedge clk);
            chk(stuck == VEC[i][0], $sformatf("R2 vector %0d", i), stuck, VEC[i][0]);
        end

        // R1: a single both-high cycle restarts the count
        do_reset();
        sda_drv = 1'b0;
        repeat (15) @(negedge clk);
        sda_drv = 1'b1;
        @(negedge clk);
        scl_drv = 1'b0;
        repeat (15) @(negedge clk);
        chk(!stuck, "R1 restart on both high", stuck, 0);
        repeat (5) @(negedge clk);
        chk(stuck, "R1 count grows on SCL low", stuck, 1);

        // full recovery with SDA held low
        do_reset();
        sda_drv = 1'b0;
        repeat (LIM + GAP - 2) @(negedge clk);
        clr_stuck = 1'b1;
        @(negedge clk);
        clr_stuck = 1'b0;
        chk(stuck, "R9 clear ignored during recovery", stuck, 1);
        repeat (2 * HALF * MAXP + 2 * HALF + 20) @(negedge clk);
        chk(disc_cnt == 1, "R4 one disconnect pulse", disc_cnt, 1);
        chk(!drv_mismatch, "R3 drv_off follows stuck", drv_mismatch, 0);
        chk(t_first - t_stuck == GAP, "R5 gap before clocks", t_first - t_stuck, GAP);
        chk(rises == MAXP + 1, "R6 pulse bound", rises - 1, MAXP);
        chk(sda_rise_scl, "R8 SDA pulled while SCL low", sda_rise_scl, 1);
        chk(!sda_fall_scl, "R8 SDA released after SCL", sda_fall_scl, 0);
        chk(t_sda_fall - t_scl_fall == HALF, "R8 STOP spacing", t_sda_fall - t_scl_fall, HALF);
        chk(stuck && !sda_pull && !scl_pull, "R9 flag held after STOP", stuck, 1);
        clr_stuck = 1'b1;
        sda_drv = 1'b1;
        @(negedge clk);
        clr_stuck = 1'b0;
        chk(!stuck && !drv_off, "R9 clear after STOP", stuck, 0);

        // R7: far device lets SDA go after its third clock
        do_reset();
        sda_drv = 1'b0;
        rel_after = 3;
        repeat (LIM + GAP + 2 * HALF * MAXP + 20) @(negedge clk);
        chk(rises == 4, "R7 early stop pulses", rises - 1, 3);
        chk(t_sda_fall - t_scl_fall == HALF, "R7 STOP follows early stop", t_sda_fall - t_scl_fall, HALF);

        // R10: disabled block ignores a stuck bus
        do_reset();
        en = 1'b0;
        sda_drv = 1'b0;
        repeat (3 * LIM) @(negedge clk);
        chk(!stuck && !disc_req, "R10 no detect while disabled", stuck, 0);
        en = 1'b1;
        repeat (LIM + GAP + 2) @(negedge clk);
        chk(scl_pull, "R10 recovery running before disable", scl_pull, 1);
        en = 1'b0;
        @(negedge clk);
        chk(!stuck && !scl_pull && !sda_pull && !drv_off, "R10 disable clears all", stuck, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule